// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from host memory into a byte FIFO that feeds a MAC. Software builds a circular chain of four-word descriptors, fills a buffer, writes the byte count and the frame-boundary flags into the control word, and hands the descriptor over by setting bit 31 of its status word. It then pulses the kick input. The engine walks the chain and streams every owned buffer's bytes into the FIFO. After each descriptor it writes the status word back with the ownership bit cleared. When it reaches a descriptor that software still owns, it parks in a suspended state until the next kick.

Host memory is reached through one 32-bit request channel with valid/ready handshaking. Writes are posted. A read is answered by exactly one `mem_rsp_valid` pulse, and only one read is ever outstanding. The MAC side is a valid/ready byte stream: a byte moves on every cycle where `mac_valid` and `mac_ready` are both high, and `mac_valid`, `mac_data` and `mac_last` hold steady while `mac_ready` is low. In store-and-forward mode the FIFO offers nothing to the MAC until a whole frame is inside it. Every frame must therefore fit in the FIFO, and buffer addresses must be word aligned.

Top module: `txd_ring_dma`

## Requirements
- R1: After reset, `mem_req_valid`, `mac_valid`, `suspended` and `kick_pending` are all low.
- R2: A descriptor is four words at byte offsets 0 (status), 4 (control), 8 (buffer address) and 12 (next pointer). The status word is read first, and the rest is read only when status bit 31 (owned by engine) is set.
- R3: The engine emits exactly control[13:0] bytes from the buffer, in ascending address order, taking the bytes of each 32-bit word least significant byte first.
- R4: Control bit 30 marks the last segment: `mac_last` is high on the final byte of such a descriptor and on no other byte. A frame that spans descriptors from a bit-29 (first) descriptor to a bit-30 descriptor comes out contiguous and in ring order.
- R5: Once its bytes are queued, each descriptor's status word is rewritten at the same address with bit 31 cleared and all other bits kept. The control word is never written, so its bits 31 and 24 survive.
- R6: The engine continues at the next pointer, and the ring wraps through the pointer of its last descriptor.
- R7: A status word read with bit 31 clear raises `suspended`, and no memory request is issued while suspended.
- R8: A `dma_kick` pulse raises `kick_pending`, which clears when a status word is fetched. A kick while suspended re-reads the descriptor that caused the suspension.
- R9: With `dma_enable` low, no descriptor is fetched and a pending kick is kept. The engine returns to the descriptor at `ring_base` and starts from there once enabled.
- R10: With `sf_mode` high, `mac_valid` rises only after a frame's last byte is in the FIFO, so with `mac_ready` held high a frame leaves without gaps.
- R11: A request or output byte that is not accepted stays valid and unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_enable | input | 1 | Engine enable; low stops at a descriptor boundary |
| dma_kick | input | 1 | One-cycle poll-demand pulse |
| sf_mode | input | 1 | 1 = store-and-forward, 0 = cut-through |
| ring_base | input | 32 | Byte address of the first descriptor |
| kick_pending | output | 1 | Kick latched, not yet consumed by a status fetch |
| suspended | output | 1 | Parked on a descriptor owned by software |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = posted write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per read |
| mem_rsp_data | input | 32 | Read data |
| mac_valid | output | 1 | Output byte valid |
| mac_ready | input | 1 | MAC accepts the byte |
| mac_data | output | 8 | Output byte |
| mac_last | output | 1 | Final byte of a frame |

## Verification
The bench targets the boundaries of the ring walk. These include a one-byte buffer, a 16-byte buffer that fills four whole words, odd lengths that end mid-word, multi-descriptor frames, and wrap-around through the last next pointer. A design that mishandled partial words would emit stray or missing bytes, and one that misplaced the last flag would split or merge frames. The bench also checks the write-back: a design that clobbered the low status bits or the control word would show up in memory. Suspension, poll demand and disable are driven as directed cases. A wrong design would run past an unowned descriptor, lose the kick, or fetch while disabled. Store-and-forward mode is checked for gap-free frames, which catches an engine that releases bytes before the frame ends.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_STAT, ST_CTRL, ST_BUF, ST_NEXT, ST_DATA, ST_PUSH, ST_WB, ST_SUSP
  } txd_state_e;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;
endpackage

// File: rtl/txd_fetch.sv
module txd_fetch
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          kick,
  input  logic [AW-1:0] ring_base,
  output logic          kick_pending,
  output logic          suspended,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [31:0]   req_wdata,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  txd_state_e       state;
  logic             waiting, kick_q, last_q, is_read, got;
  logic [AW-1:0]    cur, nxt, bufp, stat_addr_q;
  logic [31:0]      status_q, word_q;
  logic [LEN_W-1:0] remaining;
  logic [2:0]       wcnt;

  assign is_read   = (state == ST_STAT) || (state == ST_CTRL) || (state == ST_BUF) ||
                     (state == ST_NEXT) || (state == ST_DATA);
  assign req_valid = (is_read && !waiting) || (state == ST_WB);
  assign req_we    = (state == ST_WB);
  assign req_wdata = status_q & ~(32'd1 << OWN_BIT);
  assign got       = waiting && rsp_valid;

  always_comb begin
    case (state)
      ST_CTRL: req_addr = cur + AW'(4);
      ST_BUF:  req_addr = cur + AW'(8);
      ST_NEXT: req_addr = cur + AW'(12);
      ST_DATA: req_addr = bufp;
      default: req_addr = cur;
    endcase
  end

  assign out_valid    = (state == ST_PUSH);
  assign out_data     = word_q[7:0];
  assign out_last     = last_q && (remaining == LEN_W'(1));
  assign suspended    = (state == ST_SUSP);
  assign kick_pending = kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; waiting <= 1'b0; kick_q <= 1'b0; last_q <= 1'b0;
      cur <= '0; nxt <= '0; bufp <= '0; status_q <= '0; word_q <= '0;
      remaining <= '0; wcnt <= '0;
    end else begin
      if (kick) kick_q <= 1'b1;
      else if (got && state == ST_STAT) kick_q <= 1'b0;
      if (req_valid && req_ready && !req_we) waiting <= 1'b1;
      else if (rsp_valid) waiting <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!enable) cur <= ring_base;
          else if (kick_q) state <= ST_STAT;
        end
        ST_STAT: if (got) begin
          status_q <= rsp_data;
          state    <= rsp_data[OWN_BIT] ? ST_CTRL : ST_SUSP;
        end
        ST_CTRL: if (got) begin
          remaining <= rsp_data[LEN_W-1:0];
          last_q    <= rsp_data[LAST_BIT];
          state     <= ST_BUF;
        end
        ST_BUF: if (got) begin
          bufp  <= rsp_data[AW-1:0];
          state <= ST_NEXT;
        end
        ST_NEXT: if (got) begin
          nxt   <= rsp_data[AW-1:0];
          state <= (remaining == '0) ? ST_WB : ST_DATA;
        end
        ST_DATA: if (got) begin
          word_q <= rsp_data;
          bufp   <= bufp + AW'(4);
          wcnt   <= (remaining >= LEN_W'(4)) ? 3'd4 : remaining[2:0];
          state  <= ST_PUSH;
        end
        ST_PUSH: if (out_ready) begin
          word_q    <= word_q >> 8;
          remaining <= remaining - LEN_W'(1);
          wcnt      <= wcnt - 3'd1;
          if (remaining == LEN_W'(1)) state <= ST_WB;
          else if (wcnt == 3'd1) state <= ST_DATA;
        end
        ST_WB: if (req_ready) begin
          cur   <= nxt;
          state <= enable ? ST_STAT : ST_IDLE;
        end
        ST_SUSP: begin
          if (!enable) state <= ST_IDLE;
          else if (kick_q) state <= ST_STAT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker state: address of the last accepted status read
  always_ff @(posedge clk) begin
    if (!rst_n) stat_addr_q <= '0;
    else if (req_valid && req_ready && state == ST_STAT) stat_addr_q <= req_addr;
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we));
  assert_wb_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we |-> req_addr == stat_addr_q);
  assert_susp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !req_valid);
  assert_push_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/txd_fifo.sv
module txd_fifo #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sf_mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [8:0]    store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, frames;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign push      = in_valid && in_ready;
  assign out_valid = (count != '0) && (!sf_mode || frames != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = store[rd_ptr][7:0];
  assign out_last  = store[rd_ptr][8];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= {in_last, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; frames <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      count  <= count + CW'(push) - CW'(pop);
      frames <= frames + CW'(push && in_last) - CW'(pop && out_last);
    end
  end

  assert_frames_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frames <= count);
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: rtl/txd_ring_dma.sv
module txd_ring_dma #(
  parameter int AW         = 32,
  parameter int LEN_W      = 14,
  parameter int FIFO_DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_enable,
  input  logic          dma_kick,
  input  logic          sf_mode,
  input  logic [AW-1:0] ring_base,
  output logic          kick_pending,
  output logic          suspended,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          mac_valid,
  input  logic          mac_ready,
  output logic [7:0]    mac_data,
  output logic          mac_last
);
  logic       b_valid, b_ready, b_last;
  logic [7:0] b_data;

  txd_fetch #(.AW(AW), .LEN_W(LEN_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .enable(dma_enable), .kick(dma_kick),
    .ring_base(ring_base), .kick_pending(kick_pending), .suspended(suspended),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_we(mem_req_we),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .out_valid(b_valid), .out_ready(b_ready), .out_data(b_data), .out_last(b_last)
  );

  txd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .sf_mode(sf_mode),
    .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data), .in_last(b_last),
    .out_valid(mac_valid), .out_ready(mac_ready), .out_data(mac_data), .out_last(mac_last)
  );
endmodule

// File: tb/txd_ring_dma_bench.sv
module txd_ring_dma_bench;
  localparam int NDESC = 6;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] BUFB = 32'h200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_enable = 1'b0, dma_kick = 1'b0, sf_mode = 1'b1;
  logic kick_pending, suspended;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic mac_valid, mac_ready = 1'b0, mac_last;
  logic [7:0] mac_data;

  always #10 clk = ~clk;

  txd_ring_dma u_txd_ring_dma (
    .clk(clk), .rst_n(rst_n), .dma_enable(dma_enable), .dma_kick(dma_kick),
    .sf_mode(sf_mode), .ring_base(BASE), .kick_pending(kick_pending),
    .suspended(suspended), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_data(mac_data), .mac_last(mac_last)
  );

  logic [31:0] mem [256];
  logic [31:0] exp_ctrl [NDESC];
  logic [31:0] exp_stat [NDESC];
  logic [8:0]  got_q[$], exp_q[$];
  int checks = 0, fails = 0, gaps = 0;
  bit ready_rand = 1'b0, rsp_pend = 1'b0, in_frm = 1'b0;
  logic [7:0] rsp_idx = '0;

  function automatic logic [31:0] daddr(int i);
    return BASE + 32'(16 * i);
  endfunction
  function automatic logic [31:0] baddr(int i);
    return BUFB + 32'(64 * i);
  endfunction

  // memory model and MAC sink, all at the falling edge
  always @(negedge clk) begin
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = mem[rsp_idx]; rsp_pend = 1'b0;
    end else mem_rsp_valid = 1'b0;
    mem_req_ready = ($urandom % 4) != 0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[9:2]] = mem_req_wdata;
      else begin rsp_pend = 1'b1; rsp_idx = mem_req_addr[9:2]; end
    end
    mac_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n && sf_mode && in_frm && mac_ready && !mac_valid) gaps++;
    if (rst_n && mac_valid && mac_ready) begin
      got_q.push_back({mac_last, mac_data});
      in_frm = !mac_last;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic kick();
    dma_kick = 1'b1; step(1); dma_kick = 1'b0;
  endtask

  // owned descriptor with random payload; expected bytes queued in the bench
  task automatic set_desc(int i, bit first, bit last, int len, bit expect_out);
    logic [31:0] st;
    st = 32'h8000_0000 | ($urandom & 32'h0000_FFFF);
    exp_ctrl[i] = 32'h8100_0000 | (32'(last) << 30) | (32'(first) << 29) | 32'(len);
    exp_stat[i] = st & 32'h7FFF_FFFF;
    mem[daddr(i) >> 2]       = st;
    mem[(daddr(i) >> 2) + 1] = exp_ctrl[i];
    mem[(daddr(i) >> 2) + 2] = baddr(i);
    mem[(daddr(i) >> 2) + 3] = daddr((i + 1) % NDESC);
    for (int b = 0; b < len; b++) begin
      logic [7:0] v;
      int w;
      v = 8'($urandom);
      w = int'(baddr(i) >> 2) + b / 4;
      mem[w][8*(b%4) +: 8] = v;
      if (expect_out) exp_q.push_back({(last && b == len - 1), v});
    end
  endtask

  task automatic set_unowned(int i);
    mem[daddr(i) >> 2] = 32'h0;
    mem[(daddr(i) >> 2) + 3] = daddr((i + 1) % NDESC);
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!(suspended && got_q.size() >= exp_q.size() && !mac_valid) && t < 4000) begin
      step(1); t++;
    end
    chk(t < 4000, req, 32'(t), 32'd4000);
  endtask

  task automatic compare(string req);
    chk(got_q.size() == exp_q.size(), {req, " byte count"}, 32'(got_q.size()), 32'(exp_q.size()));
    for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
      chk(got_q[k] == exp_q[k], {req, " byte/last"}, 32'(got_q[k]), 32'(exp_q[k]));
    got_q.delete(); exp_q.delete();
  endtask

  task automatic check_wb(int i, string req);
    chk(mem[daddr(i) >> 2] == exp_stat[i], {req, " status writeback R5"},
        mem[daddr(i) >> 2], exp_stat[i]);
    chk(mem[(daddr(i) >> 2) + 1] == exp_ctrl[i], {req, " control kept R5"},
        mem[(daddr(i) >> 2) + 1], exp_ctrl[i]);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd2718));
    for (int a = 0; a < 256; a++) mem[a] = '0;
    for (int i = 0; i < NDESC; i++) set_unowned(i);
    step(4); rst_n = 1'b1; step(1);
    // R1 reset state
    chk(!mem_req_valid && !mac_valid, "R1 idle outputs", {30'd0, mem_req_valid, mac_valid}, 32'd0);
    chk(!suspended && !kick_pending, "R1 flags", {30'd0, suspended, kick_pending}, 32'd0);

    // directed: 1-byte frame, then 3-descriptor frame (R2 R3 R4), store-and-forward R10
    sf_mode = 1'b1; ready_rand = 1'b0; dma_enable = 1'b1;
    set_desc(0, 1, 1, 1, 1);
    set_desc(1, 1, 0, 4, 1);
    set_desc(2, 0, 0, 7, 1);
    set_desc(3, 0, 1, 16, 1);
    set_unowned(4);
    kick();
    chk(kick_pending, "R8 kick latched", {31'd0, kick_pending}, 32'd1);
    wait_done("R7 suspend on unowned");
    compare("R3 R4 directed stream");
    for (int i = 0; i < 4; i++) check_wb(i, "directed");
    chk(mem[daddr(4) >> 2] == 32'h0, "R7 unowned untouched", mem[daddr(4) >> 2], 32'h0);
    chk(!kick_pending, "R8 kick consumed", {31'd0, kick_pending}, 32'd0);
    chk(gaps == 0, "R10 no gaps", 32'(gaps), 32'd0);

    // poll demand: resumes at the descriptor it stopped on, wraps R6, cut-through
    sf_mode = 1'b0; ready_rand = 1'b1;
    set_desc(4, 1, 1, 5, 1);
    set_desc(5, 1, 1, 9, 1);
    set_unowned(0);
    step(20);
    chk(got_q.size() == 0 && suspended, "R8 waits for kick", 32'(got_q.size()), 32'd0);
    kick();
    wait_done("R8 poll demand");
    compare("R6 R8 resumed stream");
    check_wb(4, "R8"); check_wb(5, "R6");

    // disable: no fetch, kick held, restart from ring_base R9
    dma_enable = 1'b0; step(3);
    set_desc(0, 1, 1, 3, 1);
    set_unowned(1);
    kick(); step(40);
    chk(got_q.size() == 0, "R9 no output while disabled", 32'(got_q.size()), 32'd0);
    chk(mem[daddr(0) >> 2][31], "R9 own kept while disabled", mem[daddr(0) >> 2], 32'h8000_0000);
    chk(kick_pending, "R9 kick held", {31'd0, kick_pending}, 32'd1);
    dma_enable = 1'b1;
    wait_done("R9 restart");
    compare("R9 stream from base");
    check_wb(0, "R9");

    // random rounds
    k = 1;
    for (int r = 0; r < 14; r++) begin
      int cnt;
      bit prev_last;
      cnt = 1 + int'($urandom % 4);
      prev_last = 1'b1;
      sf_mode = ($urandom % 2) != 0;
      ready_rand = !sf_mode;
      gaps = 0;
      for (int j = 0; j < cnt; j++) begin
        bit lst;
        lst = (j == cnt - 1) || (($urandom % 2) != 0);
        set_desc((k + j) % NDESC, prev_last, lst, 1 + int'($urandom % 15), 1);
        prev_last = lst;
      end
      set_unowned((k + cnt) % NDESC);
      kick();
      wait_done("R7 random round");
      compare("R3 R4 R6 random stream");
      for (int j = 0; j < cnt; j++) check_wb((k + j) % NDESC, "random");
      chk(gaps == 0, "R10 random gaps", 32'(gaps), 32'd0);
      k = (k + cnt) % NDESC;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule